// File: doc/BRIEF.md
# Interleaved Display Scan Sequencer

This block produces the multiplexing timing for a nine-position vacuum fluorescent display whose segment lines also scan a key matrix. A free-running state counter divides time into digit slots. The slots visit the digit positions in an interleaved order. After every three slots the block inserts a short keyboard window, and during that window every digit driver is off.

Within each slot the digit enable is held off in the first and last state, so the segment path can change its pattern while the display is dark. A digit is driven only when the display formatter marks it as needed through a mask. The block therefore lights only the positions that carry information. A one-cycle strobe at the start of each slot tells the segment path to load the next pattern. Segment decoding and key sensing are done elsewhere.

Top module: `vfd_scan_seq`

## Requirements
- R1: `state_num` advances by one per clock. It runs 1 to 16 within a digit slot and 1 to 4 within a keyboard window.
- R2: Over successive slots, `dig_idx` runs 0, 3, 6, 1, 4, 7, 2, 5, 8 and then repeats. Index k stands for digit k+1: index 0 is the least significant digit, index 7 the most significant and index 8 the sign. During a keyboard window, `dig_idx` holds the index of the slot just finished.
- R3: A keyboard window of 4 states, with `kbd_win` high, follows every third digit slot. This gives three windows per frame and a frame length of 156 clocks.
- R4: `dig_en` is all zero in state 1 and state 16 of every digit slot, and throughout every keyboard window.
- R5: In states 2 to 15 of a slot, `dig_en` has bit `dig_idx` set when `need_mask[dig_idx]` is 1 and is zero otherwise. Bit k of both vectors refers to digit index k, so a mask of 9'h001 lights only the least significant digit.
- R6: `seg_load` is high exactly in state 1 of each digit slot and at no other time.
- R7: `rst` is synchronous. At the first clock edge at which it is high, the block returns to state 1 of the slot for index 0, with `kbd_win` low and `seg_load` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one state per period |
| rst | input | 1 | Synchronous reset, active high |
| need_mask | input | 9 | Per-digit flag from the formatter: 1 means the digit must be lit |
| dig_en | output | 9 | Digit driver enables, one-hot or zero |
| dig_idx | output | 4 | Digit index of the current or last slot |
| state_num | output | 5 | State number within the slot or window, counting from 1 |
| seg_load | output | 1 | Strobe at state 1 of each digit slot |
| kbd_win | output | 1 | High during keyboard windows |

## Verification
The bench derives every output, in every cycle, from a time counter taken modulo the frame length. It runs several frames, each with a different mask: all digits needed, a lone least significant digit, alternating patterns, no digits and the sign digit alone. With these masks the bench would catch three kinds of fault: a sequencer that steps the digits sequentially rather than interleaved, one that places the keyboard window after the wrong slot or gives it the wrong length, and one that forgets to blank the edge states and so lights a digit while its segments change. A reset issued in the middle of a frame checks that the sequencer returns to its home state rather than resuming from where it stopped.

// File: rtl/vfd_scan_seq.sv
module vfd_scan_seq #(
  parameter int DIGITS  = 9,
  parameter int GROUP   = 3,
  parameter int SLOT_ST = 16,
  parameter int KBD_ST  = 4,
  localparam int ROWS = DIGITS / GROUP,
  localparam int SW   = $clog2(SLOT_ST + 1),
  localparam int IW   = $clog2(DIGITS),
  localparam int WW   = (GROUP > 1) ? $clog2(GROUP) : 1,
  localparam int GW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIGITS-1:0] need_mask,
  output logic [DIGITS-1:0] dig_en,
  output logic [IW-1:0]     dig_idx,
  output logic [SW-1:0]     state_num,
  output logic              seg_load,
  output logic              kbd_win
);

  logic [SW-1:0] cnt;
  logic [WW-1:0] col;
  logic [GW-1:0] row;
  logic          kbd;

  wire slot_last = !kbd && (cnt == SW'(SLOT_ST - 1));
  wire kbd_last  = kbd && (cnt == SW'(KBD_ST - 1));
  wire lit       = !kbd && (cnt != '0) && (cnt != SW'(SLOT_ST - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      col <= '0;
      row <= '0;
      kbd <= 1'b0;
    end else if (slot_last) begin
      cnt <= '0;
      if (col == WW'(GROUP - 1)) kbd <= 1'b1;
      else col <= col + 1'b1;
    end else if (kbd_last) begin
      cnt <= '0;
      kbd <= 1'b0;
      col <= '0;
      row <= (row == GW'(ROWS - 1)) ? '0 : row + 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign dig_idx   = IW'(int'(col) * ROWS + int'(row));
  assign state_num = cnt + 1'b1;
  assign seg_load  = !kbd && (cnt == '0);
  assign kbd_win   = kbd;
  assign dig_en    = (lit && need_mask[dig_idx]) ? (DIGITS'(1) << dig_idx) : '0;

  AST_ONEHOT_EN: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dig_en)); // R5
  AST_STROBE_DARK: assert property (@(posedge clk) disable iff (rst)
    seg_load |-> dig_en == '0); // R4
  AST_KBD_DARK: assert property (@(posedge clk) disable iff (rst)
    kbd_win |-> (dig_en == '0 && !seg_load)); // R4
  AST_KBD_EXIT: assert property (@(posedge clk) disable iff (rst)
    $fell(kbd_win) |-> seg_load); // R6
  AST_SLOT_CLOSE: assert property (@(posedge clk) disable iff (rst)
    (!kbd_win && state_num == SW'(SLOT_ST)) |=> (seg_load || kbd_win)); // R3
  AST_STATE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!kbd_win && state_num != SW'(SLOT_ST)) |=> state_num == SW'($past(state_num) + 1'b1)); // R1
  AST_RESET_HOME: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (seg_load && dig_idx == '0 && !kbd_win)); // R7

endmodule

// File: tb/tb_vfd_scan_seq.sv
module tb_vfd_scan_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [8:0] need_mask = 9'h1ff;
  logic [8:0] dig_en;
  logic [3:0] dig_idx;
  logic [4:0] state_num;
  logic       seg_load, kbd_win;

  int nchk = 0, nfail = 0, t = 0;

  always #10 clk = ~clk;

  vfd_scan_seq dut (.clk(clk), .rst(rst), .need_mask(need_mask), .dig_en(dig_en),
                    .dig_idx(dig_idx), .state_num(state_num), .seg_load(seg_load),
                    .kbd_win(kbd_win));

  task automatic chk(string req, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0d)", req, act, exp, t);
    end
  endtask

  task automatic check_cycle();
    int tm = t % 156;
    int gi = tm / 52;
    int r  = tm % 52;
    int kb, st, idx, en;
    #1;
    if (r < 48) begin
      kb = 0; st = r % 16 + 1; idx = (r / 16) * 3 + gi;
    end else begin
      kb = 1; st = r - 48 + 1; idx = 6 + gi;
    end
    en = (kb == 0 && st != 1 && st != 16 && need_mask[idx]) ? (1 << idx) : 0;
    chk("R1 state_num", int'(state_num), st);
    chk("R2 dig_idx", int'(dig_idx), idx);
    chk("R3 kbd_win", int'(kbd_win), kb);
    chk((kb == 1 || st == 1 || st == 16) ? "R4 dig_en blank" : "R5 dig_en", int'(dig_en), en);
    chk("R6 seg_load", int'(seg_load), (kb == 0 && st == 1) ? 1 : 0);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) begin
      check_cycle();
      @(negedge clk);
      t++;
    end
  endtask

  task automatic home_check();
    #1;
    chk("R7 reset state_num", int'(state_num), 1);
    chk("R7 reset dig_idx", int'(dig_idx), 0);
    chk("R7 reset kbd_win", int'(kbd_win), 0);
    chk("R7 reset seg_load", int'(seg_load), 1);
    chk("R7 reset dig_en", int'(dig_en), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    home_check();
    rst = 1'b0;
    t = 0;
    need_mask = 9'h1ff; run(156);
    need_mask = 9'h001; run(156);
    need_mask = 9'h0aa; run(156);
    need_mask = 9'h155; run(156);
    need_mask = 9'h000; run(156);
    need_mask = 9'h100; run(156);
    need_mask = 9'h1ff; run(77);
    rst = 1'b1;
    @(negedge clk);
    home_check();
    rst = 1'b0;
    t = 0;
    run(2 * 156);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(20 * 20000);
    nchk++;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule